// File: doc/BRIEF.md
# Synchronized Single-Cycle Rise Pulser

This block watches a level signal that may change at any moment relative to the clock. Each time it finds the level high after having found it low, it emits a pulse on its output. The pulse lasts exactly one clock period and is aligned to the clock. A level that stays high for many periods still produces only one pulse. A new pulse needs at least one clock edge that samples the level low, followed by an edge that samples it high again.

Two flip-flops in series hold the sampling history. The output is decoded from their state alone, so it never follows the raw input between edges. A build parameter chooses how the second flip-flop is loaded. It can copy the first flip-flop, or it can take the AND of the input with the first flip-flop. Both choices give the same output sequence.

The block is meant for push-buttons, strobes from other clock domains and similar slow levels that must become a single-cycle event inside a synchronous design. Reset is synchronous and active low.

Top module: `level_rise_pulser`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, both history flip-flops clear and `pulse_out` is 0 for the following cycle. After release, the first edge that samples `level_in` high produces a pulse, even if the level was already high during reset.
- R2: If an edge samples `level_in` = 1 and the previous edge sampled 0, `pulse_out` is 1 for the cycle that follows that edge.
- R3: A level held high across many edges yields exactly one pulse, in the cycle after the first edge that samples it high.
- R4: After a pulse, no further pulse occurs until an edge has sampled `level_in` = 0. A single sampled 0 followed by a sampled 1 is enough to re-arm it.
- R5: `pulse_out` is never 1 in two consecutive cycles.
- R6: Both second-stage build options (`HIST_MODE` = `HIST_COPY` or `HIST_GATED`) produce identical `pulse_out` sequences for the same input.
- R7: A high excursion of `level_in` that begins and ends between two rising edges is never sampled and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| level_in | input | 1 | Level to watch; asynchronous to `clk` |
| pulse_out | output | 1 | One-period pulse per sampled low-to-high change |

## Verification
A fixed vector sequence covers the basic cases. These are an isolated single-cycle high, long highs, a one-cycle low between two highs and back-to-back toggling. Together they separate correct rise detection from a plain level follower and from a detector that fails to re-arm after a short low. Random high and low durations of one to six cycles are then checked against a reference computed from the sampled history. The same stimulus drives both second-stage build options, and their outputs are compared cycle by cycle. Directed cases cover a high held through and past reset, and a high glitch placed wholly between two edges, which must not be sampled.

// File: rtl/pulser_pkg.sv
// Shared definitions for the rise pulser.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pulser_pkg;
    // Selects how the second history stage is loaded.
    typedef enum logic {
        HIST_COPY  = 1'b0,  // second stage copies the first stage
        HIST_GATED = 1'b1   // second stage takes input AND first stage
    } hist_mode_e;
endpackage

// File: rtl/pulser_sample_stage.sv
// First history stage: captures the raw level on each rising edge.
// Assumes the level may change at any time; the output is only ever
// the value seen at the last edge.
module pulser_sample_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic sample_o
);
    // Capture the level, clear on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_o <= 1'b0;
        else        sample_o <= level_i;
    end
endmodule

// File: rtl/pulser_hist_stage.sv
// Second history stage: remembers whether the level was high one edge
// earlier. MODE picks the loading equation; both keep the decoded
// output identical because they differ only in states that are left
// on the next edge with the first stage cleared.
module pulser_hist_stage
    import pulser_pkg::*;
#(
    parameter hist_mode_e MODE = HIST_COPY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic sample_i,
    output logic hist_o
);
    logic hist_d;

    generate
        if (MODE == HIST_GATED) begin : g_gated
            // Load only when the level is still high.
            always_comb hist_d = level_i & sample_i;
        end else begin : g_copy
            // Load a plain copy of the first stage.
            always_comb hist_d = sample_i;
        end
    endgenerate

    // Register the selected next value, clear on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_o <= 1'b0;
        else        hist_o <= hist_d;
    end
endmodule

// File: rtl/level_rise_pulser.sv
// Top of the synchronized single-cycle rise pulser.
// Produces a one-period pulse after the first edge that samples the
// level high following an edge that sampled it low. The output depends
// on registered state only. Assumes rst_n is synchronous to clk.
module level_rise_pulser
    import pulser_pkg::*;
#(
    parameter hist_mode_e HIST_MODE = HIST_COPY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic pulse_out
);
    logic sampled;
    logic history;

    pulser_sample_stage u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_in),
        .sample_o (sampled)
    );

    pulser_hist_stage #(.MODE(HIST_MODE)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_in),
        .sample_i (sampled),
        .hist_o   (history)
    );

    // Moore decode: newly high now, not high one edge earlier.
    always_comb pulse_out = sampled & ~history;

    // Assertion support: counts edges since reset, saturating at two.
    logic [1:0] edges_since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                     edges_since_rst <= 2'd0;
        else if (edges_since_rst != 2'd2) edges_since_rst <= edges_since_rst + 2'd1;
    end

    // R1: reset at an edge leaves the output low afterwards.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !pulse_out);

    // R2: a sampled low-then-high pair must give a pulse.
    p_rise_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_since_rst == 2'd2 && $past(level_in) && !$past(level_in, 2)) |-> pulse_out);

    // R4: any pulse must be caused by a sampled low-then-high pair.
    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_since_rst == 2'd2 && pulse_out) |-> ($past(level_in) && !$past(level_in, 2)));

    // R5: never two pulse cycles in a row.
    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out);
endmodule

// File: tb/tb_level_rise_pulser.sv
module tb_level_rise_pulser;
    import pulser_pkg::*;

    localparam int PERIOD = 10;
    localparam int NVEC = 16;
    // bit1 = level driven before the edge, bit0 = expected pulse after it
    localparam logic [1:0] VEC [NVEC] = '{
        2'b00, 2'b11, 2'b10, 2'b10, 2'b00, 2'b11, 2'b00, 2'b00,
        2'b11, 2'b10, 2'b00, 2'b11, 2'b10, 2'b10, 2'b10, 2'b00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic level = 1'b0;
    logic pulse, pulse_alt;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    level_rise_pulser #(.HIST_MODE(HIST_COPY)) dut (
        .clk(clk), .rst_n(rst_n), .level_in(level), .pulse_out(pulse));

    level_rise_pulser #(.HIST_MODE(HIST_GATED)) dut_alt (
        .clk(clk), .rst_n(rst_n), .level_in(level), .pulse_out(pulse_alt));

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
        end
    endtask

    // Drive one edge's input, then check both builds 1 ns after the edge.
    task automatic step(input logic d, input logic r, input logic exp, input string req);
        @(negedge clk);
        level = d;
        rst_n = r;
        @(posedge clk);
        #1;
        check(req, pulse, exp);
        check("R6", pulse_alt, pulse);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic prev;
        // R1: reset state
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, "R1");

        // Vector table, starting from a sampled low.
        step(1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < NVEC; i++)
            step(VEC[i][1], 1'b1, VEC[i][0], "R2/R3/R4");

        // R1: level high through reset still gives one pulse after release.
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, "R1");
        step(1'b1, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b0, "R3");

        // R4: one sampled low re-arms the detector.
        step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, 1'b1, "R4");
        step(1'b0, 1'b1, 1'b0, "R5");

        // R7: glitch wholly between two edges is not sampled.
        @(negedge clk);
        level = 1'b0;
        #2 level = 1'b1;
        #2 level = 1'b0;
        @(posedge clk);
        #1;
        check("R7", pulse, 1'b0);
        check("R6", pulse_alt, pulse);
        step(1'b0, 1'b1, 1'b0, "R7");

        // Random high and low durations against a sampled-history model.
        prev = 1'b0;
        for (int ph = 0; ph < 400; ph++) begin
            logic d;
            int len;
            d = ph[0];
            len = 1 + int'($urandom_range(5));
            for (int k = 0; k < len; k++) begin
                step(d, 1'b1, d & ~prev, "R2 random");
                prev = d;
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule